// File: doc/BRIEF.md
# Quarter-Wave Sine Synthesizer

This block is a direct digital synthesis core. It produces a stream of signed sine samples at a frequency set by a tuning word. On every clock the tuning word is added to a phase register that wraps by natural overflow, so the phase rises as a sawtooth. The output frequency is therefore `tuning_word * f_clk / 2^ACC_W`. A value of 1 gives the slowest wrap. A value just under half scale approaches the Nyquist limit of `f_clk/2`.

Only a few upper phase bits are used. The top two bits pick the quadrant. The next `Q_W` bits address a table that holds one quarter of a sine period, and the low bits are dropped. The table is computed when the design is elaborated, so no memory file is needed. The full cycle is rebuilt in two steps. The table is read forward or backward depending on the quadrant, and the second half of the cycle is negated. A new tuning word changes only the step size and never touches the phase register, so a frequency change causes no phase jump.

Top module: `dds_sine_gen`

## Requirements
- R1: On every clock after reset the phase register advances by the active tuning word, modulo 2^ACC_W. With a tuning word of 1, the sample sequence repeats with a period of exactly 2^ACC_W clocks.
- R2: A write with `tw_wr` high stores `tw_in` at that clock edge. The new value becomes the step from the following edge on. A write never clears or otherwise alters the phase register, so the phase stays continuous. A zero tuning word holds the phase still.
- R3: Phase bits [ACC_W-1:ACC_W-2] form the quadrant q. Bits [ACC_W-3:ACC_W-2-Q_W] form the table index i. All lower bits have no effect on the sample.
- R4: Quarter-table entry k (for 0 <= k < 2^Q_W) equals round(P * sin(pi/2 * (k+0.5)/2^Q_W)), where P = 2^(AMP_W-1)-1.
- R5: Quadrant mapping. q[0]=1 reads the table at the mirrored index (2^Q_W-1-i); otherwise it reads index i. q[1]=1 negates the magnitude. The result is two's complement.
- R6: `sample_out` is registered one clock after the phase it represents. `sample_vld` is high on every clock after the first edge following reset release.
- R7: While `rst` is high, the phase, the tuning word, `sample_out` and `sample_vld` are all zero. After release with no write, the output holds at the zero-phase sample, which is table entry 0.
- R8: With a tuning word of exactly half scale (only the MSB set), consecutive samples are exact negatives of each other.
- R9: The sample at phase p equals the negative of the sample at phase p + 2^(ACC_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tw_wr | input | 1 | Tuning-word write strobe |
| tw_in | input | ACC_W | Tuning word to store |
| sample_out | output | AMP_W | Signed sine sample |
| sample_vld | output | 1 | Sample valid |

## Verification
The bench uses a reduced configuration: a 12-bit phase register and a 64-entry quarter table.

- **Tuning word of 1.** The bench steps through every phase value. This separates a correct wrap period, index slicing and quadrant fold from an off-by-one table, a wrong mirror or a wrong sign bit.
- **Half-scale tuning word.** This isolates the sign path, because every pair of consecutive samples must cancel.
- **Odd-valued tuning words, written mid-run.** These expose any reset of the phase or a late or early capture of the new step.
- **Full-period record.** The record taken with a tuning word of 1 is also checked for half-period antisymmetry and for an exact 2048/2048 split of positive and negative samples.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam real PI = 3.141592653589793;

    // Quarter-sine magnitude for entry k of a table with 'depth' entries,
    // sampled at the bin centre so the mirrored read is exactly symmetric.
    function automatic int quarter_sine(int k, int depth, int peak);
        real x;
        real term;
        real sum;
        x    = PI * (real'(k) + 0.5) / (2.0 * real'(depth));
        term = x;
        sum  = x;
        for (int n = 1; n <= 9; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            sum  = sum + term;
        end
        return $rtoi(real'(peak) * sum + 0.5);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tw_wr,
    input  logic [ACC_W-1:0] tw_in,
    output logic [ACC_W-1:0] phase,
    output logic [ACC_W-1:0] tw_cur
);

    typedef struct packed {
        logic [ACC_W-1:0] tw;
        logic [ACC_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.acc = st_q.acc + st_q.tw;
        if (tw_wr) begin
            st_d.tw = tw_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase  = st_q.acc;
    assign tw_cur = st_q.tw;

endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
    parameter int Q_W   = 8,
    parameter int MAG_W = 9
) (
    input  logic [Q_W-1:0]   addr,
    output logic [MAG_W-1:0] mag
);

    localparam int DEPTH = 1 << Q_W;
    localparam int PEAK  = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int VAL = dds_pkg::quarter_sine(k, DEPTH, PEAK);
        assign tbl[k] = MAG_W'(VAL);
    end

    assign mag = tbl[addr];

endmodule

// File: rtl/dds_fold.sv
module dds_fold #(
    parameter int ACC_W = 28,
    parameter int Q_W   = 8,
    parameter int AMP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ACC_W-1:0]        phase,
    output logic [Q_W-1:0]          rom_addr,
    input  logic [AMP_W-2:0]        rom_mag,
    output logic signed [AMP_W-1:0] sample,
    output logic                    valid
);

    typedef struct packed {
        logic signed [AMP_W-1:0] smp;
        logic                    vld;
    } out_st_t;

    out_st_t          st_d, st_q;
    logic [1:0]       quad;
    logic [Q_W-1:0]   idx;
    logic [AMP_W-1:0] mag_ext;

    assign quad = phase[ACC_W-1 -: 2];
    assign idx  = phase[ACC_W-3 -: Q_W];

    always_comb begin
        rom_addr = quad[0] ? ~idx : idx;
        mag_ext  = {1'b0, rom_mag};
        st_d     = st_q;
        st_d.smp = quad[1] ? -$signed(mag_ext) : $signed(mag_ext);
        st_d.vld = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample = st_q.smp;
    assign valid  = st_q.vld;

endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
    parameter int ACC_W = 28,
    parameter int Q_W   = 8,
    parameter int AMP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tw_wr,
    input  logic [ACC_W-1:0]        tw_in,
    output logic signed [AMP_W-1:0] sample_out,
    output logic                    sample_vld
);

    localparam int MAG_W = AMP_W - 1;

    logic [ACC_W-1:0] phase;
    logic [ACC_W-1:0] tw_cur;
    logic [Q_W-1:0]   rom_addr;
    logic [MAG_W-1:0] rom_mag;

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .tw_wr  (tw_wr),
        .tw_in  (tw_in),
        .phase  (phase),
        .tw_cur (tw_cur)
    );

    dds_quarter_rom #(.Q_W(Q_W), .MAG_W(MAG_W)) u_rom (
        .addr (rom_addr),
        .mag  (rom_mag)
    );

    dds_fold #(.ACC_W(ACC_W), .Q_W(Q_W), .AMP_W(AMP_W)) u_fold (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .rom_addr (rom_addr),
        .rom_mag  (rom_mag),
        .sample   (sample_out),
        .valid    (sample_vld)
    );

endmodule

// File: rtl/dds_sine_chk.sv
module dds_sine_chk #(
    parameter int ACC_W = 28,
    parameter int AMP_W = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tw_wr,
    input logic [ACC_W-1:0]        tw_in,
    input logic [ACC_W-1:0]        tw,
    input logic [ACC_W-1:0]        phase,
    input logic signed [AMP_W-1:0] sample,
    input logic                    vld
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> phase == ACC_W'($past(phase) + $past(tw)));

    p_tw_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(tw_wr)) |-> tw == $past(tw_in));

    p_tw_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(tw_wr)) |-> $stable(tw));

    p_sign_fold_r5: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (sample[AMP_W-1] == $past(phase[ACC_W-1]) && sample != '0));

    p_valid_on_r6: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> vld);

endmodule

bind dds_sine_gen dds_sine_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tw_wr  (tw_wr),
    .tw_in  (tw_in),
    .tw     (tw_cur),
    .phase  (phase),
    .sample (sample_out),
    .vld    (sample_vld)
);

// File: tb/sim_dds_sine_gen.sv
module sim_dds_sine_gen;

    localparam int AW   = 12;
    localparam int QW   = 6;
    localparam int OW   = 10;
    localparam int FULL = 1 << AW;
    localparam real PI  = 3.141592653589793;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst   = 1'b1;
    logic                 tw_wr = 1'b0;
    logic [AW-1:0]        tw_in = '0;
    logic signed [OW-1:0] dout;
    logic                 vld;

    dds_sine_gen #(.ACC_W(AW), .Q_W(QW), .AMP_W(OW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .tw_wr      (tw_wr),
        .tw_in      (tw_in),
        .sample_out (dout),
        .sample_vld (vld)
    );

    int checks = 0, errors = 0, c_checks = 0, c_errors = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    function automatic int model(logic [AW-1:0] a);
        int idx, mag;
        idx = int'(a[AW-3 -: QW]);
        if (a[AW-2]) idx = (1 << QW) - 1 - idx;
        mag = $rtoi(real'((1 << (OW - 1)) - 1)
                    * $sin(PI * (real'(idx) + 0.5) / (2.0 * real'(1 << QW))) + 0.5);
        return a[AW-1] ? -mag : mag;
    endfunction

    // reference timeline: phase, tuning word and registered sample
    logic [AW-1:0] acc_m = '0, tw_m = '0;
    int samp_m = 0;
    always @(posedge clk) begin
        if (rst) begin
            acc_m <= '0; tw_m <= '0; samp_m <= 0;
        end else begin
            samp_m <= model(acc_m);
            acc_m  <= acc_m + tw_m;
            if (tw_wr) tw_m <= tw_in;
        end
    end

    // R1 R2 R3 R4 R5: every cycle compared with the reference
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            c_checks++;
            if (int'(dout) != samp_m || !vld) begin
                c_errors++;
                $display("FAIL R1/R2/R3/R4/R5 actual %0d expected %0d", int'(dout), samp_m);
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_tw(logic [AW-1:0] v);
        tw_in = v;
        tw_wr = 1'b1;
        @(negedge clk);
        tw_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks + c_checks, errors + c_errors);
        $finish;
    endtask

    int rec [2 * FULL];

    initial begin
        repeat (3) @(negedge clk);
        chk(vld == 1'b0, "R7 valid in reset", int'(vld), 0);
        chk(dout == '0, "R7 sample in reset", int'(dout), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(vld == 1'b1, "R6 valid after release", int'(vld), 1);
        chk(int'(dout) == model('0), "R7 zero-phase sample", int'(dout), model('0));
        cmp_on = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(int'(dout) == model('0), "R7 hold without write", int'(dout), model('0));
        end

        // R1 R9: unit step, record two full periods
        write_tw(AW'(1));
        repeat (2) @(negedge clk);
        for (int i = 0; i < 2 * FULL; i++) begin
            rec[i] = int'(dout);
            @(negedge clk);
        end
        begin
            int pos;
            pos = 0;
            for (int i = 0; i < FULL; i++) begin
                chk(rec[i] == rec[i + FULL], "R1 period", rec[i + FULL], rec[i]);
                chk(rec[i + FULL / 2] == -rec[i], "R9 half-period symmetry",
                    rec[i + FULL / 2], -rec[i]);
                if (rec[i] > 0) pos++;
            end
            chk(pos == FULL / 2, "R5 positive half count", pos, FULL / 2);
        end

        // R8: half-scale tuning word
        write_tw(AW'(1) << (AW - 1));
        repeat (3) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            int a;
            a = int'(dout);
            @(negedge clk);
            chk(int'(dout) == -a, "R8 alternating sign", int'(dout), -a);
        end

        // R2: mid-run changes, then freeze with zero step
        write_tw(AW'(12'h7FF));
        repeat (40) @(negedge clk);
        write_tw(AW'(12'h155));
        repeat (37) @(negedge clk);
        write_tw(AW'(12'h2AB));
        repeat (45) @(negedge clk);
        write_tw('0);
        @(negedge clk);
        begin
            int held;
            held = int'(dout);
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                chk(int'(dout) == held, "R2 zero step holds phase", int'(dout), held);
            end
        end
        finish_run();
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            finish_run();
        end
    end

endmodule